// File: doc/BRIEF.md
# Segmented Approximate Adder

This block adds two 16-bit operands and returns a 16-bit sum with a carry-out. It gives up accuracy in the low byte to save logic. Each of the eight low bits uses a cheap inexact cell. The cell's carry-out is its own A input, so the low byte has no carry chain to speak of. The upper byte is exact. Its carry-in is operand bit A[7], which is the carry that the inexact chain hands upward.

The exact upper byte has two stages. A 4-bit ripple adder covers bits 11..8. A 4-bit carry-select stage covers bits 15..12. That stage runs two precomputed ripple chains, one with carry-in 0 and one with carry-in 1, and the carry leaving bit 11 picks between them. The carry-select multiplexer also produces the final carry-out.

An optional output register can be placed at the boundary. It captures the sum, the carry-out and a valid flag on a qualified input. This suits error-tolerant datapaths such as image filters or neural-network accumulation, where small errors in the low byte are acceptable.

Top module: `seg_approx_adder`

## Requirements
- R1: Result bit 0 is 0 when op_a[0] is 1, and equals op_b[0] when op_a[0] is 0 (the carry-in of the lowest cell is 0).
- R2: For each bit i from 1 to 7, with c = op_a[i-1], result bit i is (op_b[i] AND c) when op_a[i] is 1 and (op_b[i] OR c) when op_a[i] is 0.
- R3: {cout, sum[15:8]} equals op_a[15:8] + op_b[15:8] + op_a[7], computed exactly as a 9-bit value.
- R4: The upper byte and cout depend only on op_a[15:7] and op_b[15:8]; the other low operand bits do not change them.
- R5: A carry out of bit 11 reaches bit 12 correctly (for example op_a = 0x0F80, op_b = 0x0000 gives sum 0x1000).
- R6: cout is 1 exactly when the 9-bit sum of R3 exceeds 255 (for example op_a = 0xFF80, op_b = 0x0000 gives cout = 1 and sum[15:8] = 0x00).
- R7: The absolute difference between {cout, sum} and the exact op_a + op_b never exceeds 511, and its mean over all low-byte operand pairs stays below 256.
- R8: With REG_OUT = 1, a synchronous active-high rst clears sum, cout and out_valid to 0. A result accepted with in_valid = 1 appears on sum and cout one clock later, and out_valid then equals in_valid of the previous cycle.
- R9: With REG_OUT = 0 the block is combinational: sum and cout follow the operands in the same cycle, and out_valid equals in_valid.
- R10: With REG_OUT = 1, while in_valid is 0, sum and cout hold their previous values whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 16 | First operand; bit 7 also feeds the exact half |
| op_b | input | 16 | Second operand |
| sum | output | 16 | Approximate sum |
| cout | output | 1 | Carry-out of the exact upper byte |
| out_valid | output | 1 | Sum and cout are valid |

## Verification
The bound properties assume the operands carry no unknown bits and are steady around each rising edge. They also assume in_valid is low while rst is asserted. The bench meets these assumptions: it changes op_a, op_b and in_valid only at falling edges, keeps in_valid at 0 throughout reset, and always drives both operands with defined values. Under these conditions the low-byte rule, the exact upper byte, the one-cycle latency and the hold behaviour can each be checked against the sampled operands of the previous edge.

// File: rtl/seg_adder_pkg.sv
package seg_adder_pkg;

    // Result of one bit slice: sum and carry.
    typedef struct packed {
        logic s;
        logic c;
    } bit_res_t;

    // Inexact cell: carry is taken from a; the sum is chosen by a.
    function automatic bit_res_t approx_cell(input logic a, input logic b, input logic ci);
        bit_res_t r;
        r.s = a ? (b & ci) : (b | ci);
        r.c = a;
        return r;
    endfunction

    // Exact full adder cell.
    function automatic bit_res_t full_cell(input logic a, input logic b, input logic ci);
        bit_res_t r;
        r.s = a ^ b ^ ci;
        r.c = (a & b) | (ci & (a ^ b));
        return r;
    endfunction

endpackage

// File: rtl/seg_approx_low.sv
module seg_approx_low
    import seg_adder_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        bit_res_t r;
        assign r          = approx_cell(a[i], b[i], c[i]);
        assign sum[i]     = r.s;
        assign c[i+1]     = r.c;
    end

    assign cout = c[W];
endmodule

// File: rtl/seg_ripple.sv
module seg_ripple
    import seg_adder_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        bit_res_t r;
        assign r      = full_cell(a[i], b[i], c[i]);
        assign sum[i] = r.s;
        assign c[i+1] = r.c;
    end

    assign cout = c[W];
endmodule

// File: rtl/seg_carry_select.sv
module seg_carry_select #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] sum_c0, sum_c1;
    logic         co_c0, co_c1;

    seg_ripple #(.W(W)) u_chain0 (
        .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(co_c0)
    );
    seg_ripple #(.W(W)) u_chain1 (
        .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(co_c1)
    );

    // W sum multiplexers plus one carry multiplexer, all steered by cin.
    assign sum  = cin ? sum_c1 : sum_c0;
    assign cout = cin ? co_c1  : co_c0;
endmodule

// File: rtl/seg_approx_adder.sv
module seg_approx_adder #(
    parameter int W       = 16,
    parameter int LOW_W   = 8,
    parameter int RIP_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         out_valid
);
    localparam int HI_W  = W - LOW_W;
    localparam int SEL_W = HI_W - RIP_W;
    localparam int SEL_LO = LOW_W + RIP_W;

    logic [LOW_W-1:0] lo_sum;
    logic             lo_carry;
    logic [RIP_W-1:0] rip_sum;
    logic             rip_carry;
    logic [SEL_W-1:0] sel_sum;
    logic             sel_carry;
    logic [W-1:0]     sum_d;

    seg_approx_low #(.W(LOW_W)) u_low (
        .a(op_a[LOW_W-1:0]), .b(op_b[LOW_W-1:0]),
        .sum(lo_sum), .cout(lo_carry)
    );

    seg_ripple #(.W(RIP_W)) u_mid (
        .a(op_a[SEL_LO-1:LOW_W]), .b(op_b[SEL_LO-1:LOW_W]),
        .cin(lo_carry), .sum(rip_sum), .cout(rip_carry)
    );

    seg_carry_select #(.W(SEL_W)) u_top (
        .a(op_a[W-1:SEL_LO]), .b(op_b[W-1:SEL_LO]),
        .cin(rip_carry), .sum(sel_sum), .cout(sel_carry)
    );

    assign sum_d = {sel_sum, rip_sum, lo_sum};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum       <= '0;
                cout      <= 1'b0;
                out_valid <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    sum  <= sum_d;
                    cout <= sel_carry;
                end
            end
        end
    end else begin : g_comb
        assign sum       = sum_d;
        assign cout      = sel_carry;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/seg_approx_adder_chk.sv
module seg_approx_adder_chk #(
    parameter int W       = 16,
    parameter int LOW_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] sum,
    input logic         cout,
    input logic         out_valid
);
    localparam int HI_W = W - LOW_W;

    function automatic logic [LOW_W-1:0] low_ref(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [LOW_W-1:0] r;
        logic c;
        c = 1'b0;
        for (int i = 0; i < LOW_W; i++) begin
            r[i] = a[i] ? (b[i] & c) : (b[i] | c);
            c = a[i];
        end
        return r;
    endfunction

    function automatic logic [HI_W:0] hi_ref(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a[W-1:LOW_W]} + {1'b0, b[W-1:LOW_W]} + {{HI_W{1'b0}}, a[LOW_W-1]};
    endfunction

    if (REG_OUT) begin : g_seq
        // R1
        a_r1_bit0: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> sum[0] == ($past(op_a[0]) ? 1'b0 : $past(op_b[0])));
        // R2
        a_r2_low_rule: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> sum[LOW_W-1:0] == low_ref($past(op_a), $past(op_b)));
        // R3
        a_r3_high_exact: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> {cout, sum[W-1:LOW_W]} == hi_ref($past(op_a), $past(op_b)));
        // R8
        a_r8_valid_lag: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> out_valid == $past(in_valid));
        // R8
        a_r8_reset_clear: assert property (@(posedge clk)
            rst |=> !out_valid && sum == '0 && !cout);
        // R10
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(sum) && $stable(cout));
    end else begin : g_comb
        // R2
        a_r2_low_rule: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> sum[LOW_W-1:0] == low_ref(op_a, op_b));
        // R3
        a_r3_high_exact: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> {cout, sum[W-1:LOW_W]} == hi_ref(op_a, op_b));
        // R9
        a_r9_valid_pass: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end
endmodule

bind seg_approx_adder seg_approx_adder_chk #(
    .W(W), .LOW_W(LOW_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sum(sum), .cout(cout), .out_valid(out_valid)
);

// File: tb/seg_approx_adder_tb.sv
module seg_approx_adder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] op_a, op_b;
    logic [15:0] sum_r, sum_c;
    logic        cout_r, cout_c, vld_r, vld_c;

    always #5 clk = ~clk;

    seg_approx_adder #(.REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sum(sum_r), .cout(cout_r), .out_valid(vld_r)
    );

    seg_approx_adder #(.REG_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sum(sum_c), .cout(cout_c), .out_valid(vld_c)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit pend = 0;
    logic [16:0] exp_prev;
    string tag_prev;

    function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b);
        logic [7:0] lo;
        logic [8:0] hi;
        logic c;
        c = 1'b0;
        for (int i = 0; i < 8; i++) begin
            lo[i] = a[i] ? (b[i] & c) : (b[i] | c);
            c = a[i];
        end
        hi = {1'b0, a[15:8]} + {1'b0, b[15:8]} + {8'b0, a[7]};
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk({cout_r, sum_r} == exp_prev, {tag_prev, " registered R8"}, {cout_r, sum_r}, exp_prev);
            chk(vld_r == 1'b1, "R8 out_valid after accepted input", {16'b0, vld_r}, 17'd1);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input string tag);
        @(negedge clk);
        check_pending();
        op_a = a; op_b = b; in_valid = 1'b1;
        exp_prev = model(a, b);
        tag_prev = tag;
        pend = 1'b1;
        #1;
        chk({cout_c, sum_c} == exp_prev, {tag, " combinational R9"}, {cout_c, sum_c}, exp_prev);
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
        pend = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint err_sum;
        int err_max;
        logic [16:0] held;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        chk(vld_r == 1'b0, "R8 reset out_valid", {16'b0, vld_r}, 17'd0);
        chk({cout_r, sum_r} == 17'd0, "R8 reset sum", {cout_r, sum_r}, 17'd0);
        rst = 1'b0;

        // Corner cases
        apply(16'h0001, 16'h0001, "R1 a0=1");
        apply(16'h0000, 16'h0001, "R1 a0=0");
        apply(16'h0F80, 16'h0000, "R5 carry 11->12");
        apply(16'hFF80, 16'h0000, "R6 cout set");
        apply(16'hFFFF, 16'hFFFF, "R6 all ones");
        apply(16'h0000, 16'h0000, "R6 all zeros");

        // Exhaustive low byte; error statistics
        err_sum = 0; err_max = 0;
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                logic [15:0] a, b;
                int d;
                a = {8'h5A ^ 8'(ai), 8'(ai)};
                b = {8'hC3, 8'(bi)};
                apply(a, b, "R1/R2/R3");
                d = int'(model(a, b)) - (int'(a) + int'(b));
                if (d < 0) d = -d;
                err_sum += d;
                if (d > err_max) err_max = d;
            end
        end
        chk(err_max <= 511, "R7 max error", 17'(err_max), 17'd511);
        chk(err_sum < 64'd256 * 64'd65536, "R7 mean error below 256", 17'(err_sum / 65536), 17'd255);

        // Upper byte sweep: R3, R4, R5, R6
        for (int ah = 0; ah < 256; ah++) begin
            for (int bs = 0; bs < 16; bs++) begin
                for (int a7 = 0; a7 < 2; a7++) begin
                    apply({8'(ah), 1'(a7), 7'h15}, {8'(bs * 17), 8'h6C}, "R3/R5/R6 high sweep");
                end
            end
        end

        // R4: same high inputs, different low bits, same upper result
        apply(16'h3A80, 16'h4C00, "R4 low pattern 1");
        apply(16'h3AFF, 16'h4C7F, "R4 low pattern 2");
        apply(16'h3AC3, 16'h4C29, "R4 low pattern 3");

        // R10: hold while in_valid low; R9 comb pass of valid
        apply(16'h1234, 16'h0F0F, "R10 last accepted");
        flush();
        held = {cout_r, sum_r};
        op_a = 16'hFFFF; op_b = 16'h8001;
        #1;
        chk(vld_c == 1'b0, "R9 out_valid follows in_valid low", {16'b0, vld_c}, 17'd0);
        chk({cout_c, sum_c} == model(16'hFFFF, 16'h8001), "R9 comb follows operands", {cout_c, sum_c}, model(16'hFFFF, 16'h8001));
        repeat (2) begin
            @(negedge clk);
            chk({cout_r, sum_r} == held, "R10 hold", {cout_r, sum_r}, held);
            chk(vld_r == 1'b0, "R8 out_valid low", {16'b0, vld_r}, 17'd0);
            op_a = ~op_a;
        end
        chk(held == model(16'h1234, 16'h0F0F), "R10 held value", held, model(16'h1234, 16'h0F0F));

        // Reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        chk({cout_r, sum_r} == 17'd0, "R8 reset clears sum", {cout_r, sum_r}, 17'd0);
        rst = 1'b0;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule